// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is an 8-bit synchronous serial port. Every transfer sends a byte on the serial data output and collects a byte from the serial data input at the same time. Software works through three registers on a small register bus. The data register loads the transmit byte into an internal shift register and returns the last byte received. The control register picks the operating mode, the idle level of the serial clock and the enable. A read-only status register reports whether the receive buffer holds a byte that has not been read.

As a master, the port drives the serial clock. The clock rate comes from the system clock divided by 4, 16 or 64, or from an external timer pulse, with each pulse toggling the clock. As a slave, the port takes the serial clock from outside and resamples it on the system clock. In slave mode, an active-low select input can gate the port. A one-cycle interrupt pulse marks the end of each byte. Sticky flags record two faults: a data write made while a transfer is running, and a byte that arrives while the buffer is still full.

The register bus never stalls and has no back-pressure. Each write and read takes effect in the cycle it is presented. Overruns in either direction are reported through the two sticky flags instead of being held off.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, and `irq`, `sclk_o` and `sdo` are low.
- R2: Control register (bus address 1): bit 7 is the write-collision flag, bit 6 is the receive-overflow flag, bit 5 is the enable, bit 4 is the clock idle level and bits 3:0 are the mode. Bits 5:0 read back as written. Writing 0 to bit 7 or bit 6 clears that flag. Writing 1 to either bit leaves that flag unchanged.
- R3: In a master mode (0000 to 0011), a write to the data register (bus address 0) starts a transfer. The transfer gives 8 clock pulses on `sclk_o`, which idles at the level of control bit 4. The MSB goes out first on `sdo`, and `sdo` changes only on trailing edges. `sdi` is sampled on each leading edge, where a leading edge is the first edge away from the idle level.
- R4: The `sclk_o` period is 4, 16 or 64 system clocks for modes 0000, 0001 and 0010. In mode 0011, each one-cycle `tmr_pulse` toggles `sclk_o`, so one clock period spans two pulses.
- R5: When a byte completes and the buffer is empty, the received byte is copied into the data register and status bit 0 (buffer full) is set. `irq` is high for exactly one cycle at the end of every completed byte.
- R6: A bus read of the data register clears status bit 0.
- R7: If a byte completes while status bit 0 is still set, the data register keeps its old value and control bit 6 is set. `irq` still pulses.
- R8: A data write made during a transfer is dropped and sets control bit 7. The running transfer continues with its original byte.
- R9: While control bit 5 is clear, the shift logic is held reset. A running transfer stops, `sclk_o` returns to the idle level, no completion occurs and data writes are ignored.
- R10: Mode 0101 is a slave mode. The port shifts on edges of `sclk_i`, using the same sampling and shifting edges as in R3, and ignores `ss_n`. A data write loads the byte for `sdo`.
- R11: Mode 0100 is a slave mode gated by `ss_n`. Serial clock edges count only while `ss_n` is low. A rising `ss_n` abandons the current byte and restarts the bit count.
- R12: Modes 0110 to 1111 are inactive. A data write then starts no transfer and `sclk_o` stays at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of the data register clears buffer full) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| tmr_pulse | input | 1 | One-cycle timer match pulse, the master clock source in mode 0011 |
| sclk_i | input | 1 | Serial clock in (slave modes) |
| sclk_o | output | 1 | Serial clock out (master modes; idle level otherwise) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| ss_n | input | 1 | Active-low slave select |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions check several rules on every cycle. Flags rise only for their proper cause: buffer full on a completion, collision on a busy write, and overflow on a completion into a full buffer. An overflow leaves the buffer frozen, and the completion pulse never lasts two cycles. The master clock holds still between divider ticks, and disabling the port clears any transfer in flight. The bench scenarios cover what needs a whole byte to show: bit order and received data for each clock mode and polarity, the measured clock periods, the timer-driven rate, slave transfers with and without select gating, the select abort, and the absence of any clock activity in inactive modes or after disable.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int CTRL_COLL = 7;
  localparam int CTRL_OVER = 6;
  localparam int CTRL_ON   = 5;
  localparam int CTRL_IDLE = 4;

  typedef enum logic [3:0] {
    MODE_M_DIV_A = 4'd0,
    MODE_M_DIV_B = 4'd1,
    MODE_M_DIV_C = 4'd2,
    MODE_M_TIMER = 4'd3,
    MODE_S_GATED = 4'd4,
    MODE_S_OPEN  = 4'd5
  } port_mode_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  input  logic       tmr_pulse,
  output logic       tick
);
  localparam int DMAX = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                        : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
  localparam int HMAX = DMAX / 2;
  localparam int CW   = (HMAX > 1) ? $clog2(HMAX) : 1;

  logic [CW-1:0] cnt, lim;
  logic          use_tmr;

  always_comb begin
    case (sel)
      2'd0:    lim = CW'(DIV_A / 2 - 1);
      2'd1:    lim = CW'(DIV_B / 2 - 1);
      default: lim = CW'(DIV_C / 2 - 1);
    endcase
  end

  assign use_tmr = (sel == 2'd3);
  assign tick    = run && (use_tmr ? tmr_pulse : (cnt == lim));

  // Half-period counter, held at zero between transfers
  always_ff @(posedge clk) begin
    if (!rst_n)                                cnt <= '0;
    else if (!run || use_tmr || (cnt == lim))  cnt <= '0;
    else                                       cnt <= cnt + 1'b1;
  end

  // R4: divider ticks are never back to back
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !use_tmr && tick) |=> !tick);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         is_master,
  input  logic         cpol,
  input  logic         ss_used,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         tick,
  input  logic         sclk_i,
  input  logic         sdi,
  input  logic         ss_n,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_data,
  output logic         sdo,
  output logic         sclk_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic         sclk_s, sdi_s, ss_s, sclk_q, ss_q;
  logic         mlvl, samp, lead, trail, din, sel_ok, ss_rise;
  logic         s_edge, s_lead, s_trail, m_lead, m_trail;
  logic [W-1:0] shreg, shifted;
  logic [CW-1:0] bitcnt;

  spi_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk_i, sdi, ss_n}),
    .q     ({sclk_s, sdi_s, ss_s})
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      ss_q   <= ss_s;
    end
  end

  always_comb begin
    s_edge  = sclk_s ^ sclk_q;
    s_lead  = s_edge && (sclk_s != cpol);
    s_trail = s_edge && (sclk_s == cpol);
    sel_ok  = !ss_used || !ss_s;
    ss_rise = ss_used && ss_s && !ss_q;
    m_lead  = busy && tick && (mlvl == cpol);
    m_trail = busy && tick && (mlvl != cpol);
    lead    = is_master ? m_lead  : (s_lead && sel_ok);
    trail   = is_master ? m_trail : (s_trail && sel_ok && busy);
    din     = is_master ? sdi : sdi_s;
    shifted = {shreg[W-2:0], samp};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      bitcnt  <= '0;
      shreg   <= '0;
      samp    <= 1'b0;
      mlvl    <= 1'b0;
      rx_data <= '0;
    end else if (!active) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      bitcnt <= '0;
      shreg  <= '0;
      samp   <= 1'b0;
      mlvl   <= cpol;
    end else begin
      done <= 1'b0;
      if (!busy)                  mlvl <= cpol;
      else if (is_master && tick) mlvl <= ~mlvl;

      if (load) begin
        shreg <= load_data;
        if (is_master) begin
          busy   <= 1'b1;
          bitcnt <= '0;
        end
      end else if (!is_master && ss_rise) begin
        busy   <= 1'b0;
        bitcnt <= '0;
      end else if (lead) begin
        samp <= din;
        busy <= 1'b1;
      end else if (trail) begin
        shreg <= shifted;
        if (bitcnt == CW'(W - 1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_data <= shifted;
          bitcnt  <= '0;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  assign sdo    = shreg[W-1];
  assign sclk_o = (is_master && active && busy) ? mlvl : cpol;

  // R5: completion is a single-cycle pulse
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: a disabled port drops any transfer
  assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!busy && !done));
  // R4: master clock moves only on divider ticks
  assert_sclk_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && is_master && busy && !tick) |=> ($stable(sclk_o) || !active));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16,
  parameter int DIV_C       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tmr_pulse,
  input  logic          sclk_i,
  output logic          sclk_o,
  input  logic          sdi,
  output logic          sdo,
  input  logic          ss_n,
  output logic          irq
);
  logic          coll_q, over_q, on_q, idle_q;
  logic [3:0]    mode_q;
  logic [DW-1:0] buf_q;
  logic          full_q;

  logic mode_ok, is_master, active, ss_used;
  logic wr_data, wr_ctrl, rd_buf, load, collide, full_live, over_set;
  logic busy, done, tick;
  logic [DW-1:0] rx_data;

  assign mode_ok   = (mode_q <= MODE_S_OPEN);
  assign is_master = (mode_q[3:2] == 2'b00);
  assign ss_used   = (mode_q == MODE_S_GATED);
  assign active    = on_q && mode_ok;

  assign wr_data   = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
  assign rd_buf    = bus_rd && (bus_addr == ADDR_DATA);
  assign load      = wr_data && active && !busy;
  assign collide   = wr_data && active && busy;
  assign full_live = full_q && !rd_buf;
  assign over_set  = done && full_live;

  spi_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy && is_master),
    .sel       (mode_q[1:0]),
    .tmr_pulse (tmr_pulse),
    .tick      (tick)
  );

  spi_shifter #(.W(DW), .SYNC_STAGES(SYNC_STAGES)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .is_master (is_master),
    .cpol      (idle_q),
    .ss_used   (ss_used),
    .load      (load),
    .load_data (bus_wdata),
    .tick      (tick),
    .sclk_i    (sclk_i),
    .sdi       (sdi),
    .ss_n      (ss_n),
    .busy      (busy),
    .done      (done),
    .rx_data   (rx_data),
    .sdo       (sdo),
    .sclk_o    (sclk_o)
  );

  // Control register with write-zero-to-clear fault flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coll_q <= 1'b0;
      over_q <= 1'b0;
      on_q   <= 1'b0;
      idle_q <= 1'b0;
      mode_q <= '0;
    end else begin
      if (wr_ctrl) begin
        on_q   <= bus_wdata[CTRL_ON];
        idle_q <= bus_wdata[CTRL_IDLE];
        mode_q <= bus_wdata[3:0];
      end
      coll_q <= collide  | (coll_q & ~(wr_ctrl & ~bus_wdata[CTRL_COLL]));
      over_q <= over_set | (over_q & ~(wr_ctrl & ~bus_wdata[CTRL_OVER]));
    end
  end

  // Receive buffer and its full flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
    end else if (done && !full_live) begin
      buf_q  <= rx_data;
      full_q <= 1'b1;
    end else if (rd_buf) begin
      full_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_DATA: bus_rdata = buf_q;
      ADDR_CTRL: bus_rdata = DW'({coll_q, over_q, on_q, idle_q, mode_q});
      ADDR_STAT: bus_rdata = DW'(full_q);
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = done;

  // R8: collision flag rises only on a data write during a transfer
  assert_coll_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_q) |-> $past(wr_data && busy));
  // R5: buffer full rises only on a completion
  assert_full_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(done));
  // R7: overflow rises only on a completion into a full buffer
  assert_over_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over_q) |-> $past(done && full_q && !rd_buf));
  // R7: buffer contents survive an overflow
  assert_buf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full_q && !rd_buf) |=> $stable(buf_q));
endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tmr_pulse = 1'b0, sclk_i = 1'b0, sdi = 1'b0, ss_n = 1'b1;
  logic       sclk_o, sdo, irq;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, irq_cnt = 0, tog = 0, tcnt = 0;
  logic sclk_prev = 1'b0;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_pulse(tmr_pulse), .sclk_i(sclk_i), .sclk_o(sclk_o), .sdi(sdi),
    .sdo(sdo), .ss_n(ss_n), .irq(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (irq === 1'b1) irq_cnt <= irq_cnt + 1;
    if (sclk_o !== sclk_prev) tog <= tog + 1;
    sclk_prev <= sclk_o;
  end

  initial forever begin
    @(negedge clk);
    tcnt = tcnt + 1;
    tmr_pulse = (tcnt % 5 == 0);
  end

  // vector: mode, idle level, tx byte, sdi pattern, expected period
  localparam logic [28:0] VEC [6] = '{
    {4'd0, 1'b0, 8'hA5, 8'h3C, 8'd4},
    {4'd1, 1'b1, 8'h5A, 8'hC3, 8'd16},
    {4'd2, 1'b0, 8'h81, 8'h7E, 8'd64},
    {4'd3, 1'b1, 8'hF0, 8'h0F, 8'd10},
    {4'd0, 1'b1, 8'h00, 8'hFF, 8'd4},
    {4'd1, 1'b0, 8'hFF, 8'h00, 8'd16}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cfg(input logic [3:0] mode, input logic idle);
    wr(2'd1, 8'h00);
    wr(2'd1, {2'b00, 1'b1, idle, mode});
  endtask

  task automatic wait_lvl(input logic lvl);
    int n = 0;
    while (sclk_o !== lvl && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic master_xfer(input logic idle, input logic [7:0] pat,
                             output logic [7:0] sent, output int per);
    int t0 = 0;
    per = 0;
    for (int i = 0; i < 8; i++) begin
      wait_lvl(~idle);
      if (i == 0) t0 = cyc;
      if (i == 1) per = cyc - t0;
      sent[7-i] = sdo;
      wait_lvl(idle);
      if (i < 7) sdi = pat[6-i];
    end
  endtask

  task automatic slave_xfer(input logic idle, input logic [7:0] mosi, input int nbits,
                            output logic [7:0] miso);
    miso = 8'h00;
    sdi = mosi[7];
    for (int i = 0; i < nbits; i++) begin
      repeat (6) @(negedge clk);
      miso[7-i] = sdo;
      sclk_i = ~idle;
      repeat (6) @(negedge clk);
      sclk_i = idle;
      if (i < 7) sdi = mosi[6-i];
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d, sent;
    int per, ic, tg;
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] d, sent;
    int per, ic, tg;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, d); check("R1 ctrl", d, 8'h00);
    rd(2'd2, d); check("R1 status", d, 8'h00);
    check("R1 sclk_o", sclk_o, 1'b0);
    check("R1 irq", irq_cnt, 0);
    check("R1 sdo", sdo, 1'b0);

    // R2 writing ones to the flag bits does not set them
    wr(2'd1, 8'hFF); rd(2'd1, d); check("R2 flags not set by 1", d, 8'h3F);
    wr(2'd1, 8'h00);

    // Vector table: master transfers (R3 R4 R5 R6)
    for (int v = 0; v < 6; v++) begin
      logic [3:0] m; logic ip; logic [7:0] tx, pat, prd;
      {m, ip, tx, pat, prd} = VEC[v];
      cfg(m, ip);
      check("R3 idle level", sclk_o, ip);
      ic = irq_cnt;
      sdi = pat[7];
      wr(2'd0, tx);
      master_xfer(ip, pat, sent, per);
      repeat (4) @(negedge clk);
      check("R3 sent bits", sent, tx);
      check("R4 period", per, prd);
      check("R3 idle after", sclk_o, ip);
      check("R5 irq once", irq_cnt - ic, 1);
      rd(2'd2, d); check("R5 full set", d, 8'h01);
      rd(2'd0, d); check("R3 received", d, pat);
      rd(2'd2, d); check("R6 full cleared", d, 8'h00);
    end

    // R7 overflow keeps the first byte
    cfg(4'd0, 1'b0);
    ic = irq_cnt;
    sdi = 1'b0; wr(2'd0, 8'h12); master_xfer(1'b0, 8'h11, sent, per);
    sdi = 1'b0; wr(2'd0, 8'h34); master_xfer(1'b0, 8'h22, sent, per);
    repeat (4) @(negedge clk);
    check("R7 irq both", irq_cnt - ic, 2);
    rd(2'd1, d); check("R7 overflow flag", d[6], 1'b1);
    // R2 write 1 keeps, write 0 clears
    wr(2'd1, 8'h60); rd(2'd1, d); check("R2 flag kept", d, 8'h60);
    wr(2'd1, 8'h20); rd(2'd1, d); check("R2 flag cleared", d, 8'h20);
    rd(2'd0, d); check("R7 buffer kept", d, 8'h11);

    // R8 collision
    cfg(4'd2, 1'b0);
    sdi = 1'b1;
    wr(2'd0, 8'hC6);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h39);
    master_xfer(1'b0, 8'hE1, sent, per);
    repeat (4) @(negedge clk);
    check("R8 original byte sent", sent, 8'hC6);
    rd(2'd1, d); check("R8 collision flag", d[7], 1'b1);
    rd(2'd0, d); check("R8 transfer completed", d, 8'hE1);

    // R9 disable mid-transfer
    cfg(4'd2, 1'b0);
    ic = irq_cnt;
    wr(2'd0, 8'hAA);
    repeat (40) @(negedge clk);
    wr(2'd1, 8'h02);
    repeat (5) @(negedge clk);
    check("R9 sclk idle", sclk_o, 1'b0);
    repeat (300) @(negedge clk);
    check("R9 no completion", irq_cnt - ic, 0);
    rd(2'd2, d); check("R9 buffer empty", d, 8'h00);
    wr(2'd0, 8'h77);
    wr(2'd1, 8'h22);
    tg = tog;
    repeat (300) @(negedge clk);
    check("R9 write ignored", tog - tg, 0);
    check("R9 write ignored irq", irq_cnt - ic, 0);

    // R10 slave without select, both idle levels
    ss_n = 1'b1;
    sclk_i = 1'b0; cfg(4'd5, 1'b0);
    ic = irq_cnt;
    wr(2'd0, 8'h3A);
    slave_xfer(1'b0, 8'hC5, 8, sent);
    check("R10 slave out", sent, 8'h3A);
    rd(2'd0, d); check("R10 slave in", d, 8'hC5);
    check("R10 irq", irq_cnt - ic, 1);
    sclk_i = 1'b1; cfg(4'd5, 1'b1);
    wr(2'd0, 8'h96);
    slave_xfer(1'b1, 8'h69, 8, sent);
    check("R10 slave out idle high", sent, 8'h96);
    rd(2'd0, d); check("R10 slave in idle high", d, 8'h69);

    // R11 select gating and abort
    sclk_i = 1'b0; ss_n = 1'b1; cfg(4'd4, 1'b0);
    ic = irq_cnt;
    wr(2'd0, 8'h00);
    slave_xfer(1'b0, 8'h5F, 8, sent);
    check("R11 deselected no irq", irq_cnt - ic, 0);
    rd(2'd2, d); check("R11 deselected buffer empty", d, 8'h00);
    ss_n = 1'b0;
    slave_xfer(1'b0, 8'hE0, 3, sent);
    ss_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R11 abort no irq", irq_cnt - ic, 0);
    ss_n = 1'b0;
    slave_xfer(1'b0, 8'hB4, 8, sent);
    check("R11 one irq after restart", irq_cnt - ic, 1);
    rd(2'd0, d); check("R11 restarted byte", d, 8'hB4);
    ss_n = 1'b1;

    // R12 inactive modes
    foreach (VEC[k]) if (k < 2) begin
      cfg(k == 0 ? 4'd6 : 4'd15, 1'b0);
      ic = irq_cnt; tg = tog;
      wr(2'd0, 8'h5C);
      repeat (300) @(negedge clk);
      check("R12 no clock", tog - tg, 0);
      check("R12 no irq", irq_cnt - ic, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule